// File: doc/BRIEF.md
# Edge-Pulse Encoder with Refresh

This block is the sending side of a channel that carries a single logic level across a barrier as short pulses only. A rising level on the input produces a one-cycle pulse on a set line, and a falling level produces a one-cycle pulse on a clear line. The receiver holds a latch that these pulses set and clear. Level alone is never transmitted.

A long idle input would leave the receiver with nothing to confirm its state. To cover this, the block restates the present level with a pulse whenever a full refresh period passes without one. It keeps doing so for as long as the input stays unchanged. The refresh period is a parameter in clock cycles and must be at least 2.

An enable input acts as the supply-good indication. While it is low, nothing is sent. In the first enabled cycle, the block announces the current level at once.

Top module: `edge_pulse_tx`

## Requirements
- R1: With enable held high, a rising edge on `data_i` produces a pulse on `set_o` in the third clock cycle after the edge is sampled. Two cycles are spent in the synchroniser and one in the output register.
- R2: With enable held high, a falling edge on `data_i` produces a pulse on `clr_o` with the same three-cycle latency.
- R3: Every pulse is exactly one clock cycle wide. No pulse appears on a cycle without a cause.
- R4: If a full `REFRESH_CYCLES` period passes after the last pulse with no edge, a refresh pulse is sent. It goes on `set_o` when the synchronised level is 1 and on `clr_o` when it is 0.
- R5: While the input stays unchanged, refresh pulses repeat exactly every `REFRESH_CYCLES` cycles.
- R6: When `enable_i` is sampled low, both outputs are low in the following cycle. No edge or refresh pulse is sent during lockout.
- R7: In the first cycle that `enable_i` is sampled high after lockout or reset, one pulse is sent for the current synchronised level, without waiting for an edge. The refresh period then restarts.
- R8: Every pulse restarts the refresh period. If an edge and a due refresh fall in the same cycle, only one pulse is sent, and the next refresh follows a full period after it.
- R9: `set_o` and `clr_o` are never high in the same cycle.
- R10: While the synchronous active-high reset is held, both outputs are low. Reset clears the timer, the synchroniser and the stored previous level.
- R11: The input passes through a two-flop synchroniser. A change on `data_i` causes no pulse in the first two cycles after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| enable_i | input | 1 | Supply-good enable; low suppresses all pulses |
| data_i | input | 1 | Asynchronous logic input to transmit |
| set_o | output | 1 | One-cycle pulse announcing level 1 |
| clr_o | output | 1 | One-cycle pulse announcing level 0 |

## Verification
The assertions assume that `enable_i` is synchronous to the clock. They also assume that `REFRESH_CYCLES` is at least 2; otherwise back-to-back refresh pulses of the same polarity would be legal. The stimulus changes `enable_i` and `data_i` only on the falling clock edge. The bench uses a refresh period of 16 cycles. Input hold times are drawn both shorter and longer than that period, and in a directed sweep an edge is placed on every offset around the cycle in which a refresh falls due.

// File: rtl/epe_pkg.sv
package epe_pkg;

    // Registered state of the pulse controller
    typedef struct packed {
        logic lvl_prev;   // synchronised level seen in the previous cycle
        logic armed;      // enable was already high in the previous cycle
        logic set_p;      // set pulse output register
        logic clr_p;      // clear pulse output register
    } epe_state_t;

endpackage

// File: rtl/epe_sync.sv
module epe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = d_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) sh_q <= '0;
        else       sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/epe_timer.sv
module epe_timer #(
    parameter int PERIOD = 100
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    output logic due_o
);
    localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LAST_C = W'(PERIOD - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (clear_i) cnt_d = '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign due_o = (cnt_q == LAST_C);

    // R5: the count is restarted by the controller no later than its last value
    a_r5_count_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST_C);

    // R8: a clear always returns the count to zero
    a_r8_clear_restarts: assert property (@(posedge clk_i) disable iff (rst_i)
        clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/edge_pulse_tx.sv
module edge_pulse_tx
    import epe_pkg::*;
#(
    parameter int REFRESH_CYCLES = 100,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic enable_i,
    input  logic data_i,
    output logic set_o,
    output logic clr_o
);
    logic       lvl;
    logic       due;
    logic       tmr_clear;
    logic       is_edge;
    logic       fire;
    epe_state_t st_d, st_q;

    epe_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (data_i),
        .q_o   (lvl)
    );

    epe_timer #(.PERIOD(REFRESH_CYCLES)) timer_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (tmr_clear),
        .due_o   (due)
    );

    always_comb begin
        st_d          = st_q;
        st_d.set_p    = 1'b0;
        st_d.clr_p    = 1'b0;
        st_d.lvl_prev = lvl;
        is_edge       = (lvl != st_q.lvl_prev);
        fire          = 1'b0;
        tmr_clear     = 1'b1;
        if (!enable_i) begin
            st_d.armed = 1'b0;
        end else begin
            st_d.armed = 1'b1;
            // startup announce, then edge, then refresh; any one restarts the period
            if (!st_q.armed)  fire = 1'b1;
            else if (is_edge) fire = 1'b1;
            else if (due)     fire = 1'b1;
            st_d.set_p = fire & lvl;
            st_d.clr_p = fire & ~lvl;
            tmr_clear  = fire;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign set_o = st_q.set_p;
    assign clr_o = st_q.clr_p;

    a_r9_never_both: assert property (@(posedge clk_i) disable iff (rst_i)
        !(set_o && clr_o));

    a_r6_lockout_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        !enable_i |=> (!set_o && !clr_o));

    a_r1_rise_sets: assert property (@(posedge clk_i) disable iff (rst_i)
        (enable_i && $past(enable_i) && $rose(lvl)) |=> set_o);

    a_r2_fall_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (enable_i && $past(enable_i) && $fell(lvl)) |=> clr_o);

    a_r3_set_one_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
        set_o |=> !set_o);

    a_r3_clr_one_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_o |=> !clr_o);

    a_r7_release_announces: assert property (@(posedge clk_i) disable iff (rst_i)
        (enable_i && !$past(enable_i)) |=> (set_o || clr_o));
endmodule

// File: tb/edge_pulse_tx_tb_top.sv
module edge_pulse_tx_tb_top;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic din = 1'b0;
    logic set_o, clr_o;

    int checks = 0;
    int fails  = 0;

    edge_pulse_tx #(.REFRESH_CYCLES(N), .SYNC_STAGES(2)) dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .enable_i (en),
        .data_i   (din),
        .set_o    (set_o),
        .clr_o    (clr_o)
    );

    always #5 clk = ~clk;

    // Requirement-level expectation, advanced once per rising edge
    logic  m_s1, m_s2, m_prev, m_arm, e_set, e_clr;
    int    m_cnt;
    string why = "R10";

    always @(posedge clk) begin
        logic lv, fire;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_arm = 0; m_cnt = 0;
            e_set = 0; e_clr = 0; why = "R10";
        end else begin
            lv = m_s2; fire = 0;
            if (!en) begin
                m_arm = 0; m_cnt = 0; why = "R6";
            end else begin
                if (!m_arm) begin fire = 1; why = "R7"; end
                else if (lv != m_prev) begin
                    fire = 1;
                    if (m_cnt == N-1) why = "R8";
                    else              why = lv ? "R1" : "R2";
                end else if (m_cnt == N-1) begin fire = 1; why = "R4"; end
                else why = "R3";
                m_arm = 1;
                m_cnt = fire ? 0 : m_cnt + 1;
            end
            m_prev = lv;
            e_set = fire && lv;
            e_clr = fire && !lv;
            m_s2 = m_s1; m_s1 = din;
        end
    end

    task automatic check(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %s expected %s at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: wait to the falling edge, compare both outputs with the expectation
    task automatic tick();
        @(negedge clk);
        check(set_o === e_set && clr_o === e_clr, why,
              $sformatf("set=%b clr=%b", set_o, clr_o),
              $sformatf("set=%b clr=%b", e_set, e_clr));
        check(!(set_o && clr_o), "R9", $sformatf("set=%b clr=%b", set_o, clr_o), "not both");
    endtask

    task automatic wait_pulse();
        for (int i = 0; i < 4*N; i++) begin
            tick();
            if (set_o || clr_o) return;
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R10: outputs idle under reset
        for (int i = 0; i < 4; i++) begin
            din = i[0]; en = 1'b1;
            @(negedge clk);
            check(!set_o && !clr_o, "R10", $sformatf("set=%b clr=%b", set_o, clr_o), "set=0 clr=0");
        end
        din = 1'b0; en = 1'b1;
        @(negedge clk); rst = 1'b0;
        // R7: first enabled cycle announces level 0
        tick();
        check(clr_o === 1'b1, "R7", $sformatf("clr=%b", clr_o), "clr=1");
        for (int i = 0; i < 5; i++) tick();

        // R11 and R1: rise sampled, no pulse for two cycles, set on the third
        din = 1'b1;
        tick(); check(!set_o, "R11", $sformatf("set=%b", set_o), "set=0");
        tick(); check(!set_o, "R11", $sformatf("set=%b", set_o), "set=0");
        tick(); check(set_o === 1'b1, "R1", $sformatf("set=%b", set_o), "set=1");
        for (int i = 0; i < 4; i++) tick();
        // R2: falling edge
        din = 1'b0;
        tick(); tick(); tick();
        check(clr_o === 1'b1, "R2", $sformatf("clr=%b", clr_o), "clr=1");

        // R4 and R5: hold high, count refresh pulses over four periods
        din = 1'b1;
        tick(); tick(); tick();
        begin
            int cnt_set = 0, cnt_clr = 0;
            for (int i = 0; i < 4*N; i++) begin
                tick();
                if (set_o) cnt_set++;
                if (clr_o) cnt_clr++;
            end
            check(cnt_set == 4 && cnt_clr == 0, "R5",
                  $sformatf("set=%0d clr=%0d", cnt_set, cnt_clr), "set=4 clr=0");
            check(set_o === 1'b1, "R4", $sformatf("set=%b", set_o), "set=1 at period end");
        end

        // R6: lockout while toggling the input
        en = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < 3*N; i++) begin
                if (i % 5 == 0) din = ~din;
                tick();
                if (set_o || clr_o) seen++;
            end
            check(seen == 0, "R6", $sformatf("pulses=%0d", seen), "pulses=0");
        end
        din = 1'b1;
        tick(); tick(); tick();
        // R7: release announces current level 1
        en = 1'b1;
        tick();
        check(set_o === 1'b1, "R7", $sformatf("set=%b", set_o), "set=1");

        // R8: edge placed at every offset around the refresh due time
        for (int off = N-6; off <= N+1; off++) begin
            wait_pulse();
            for (int i = 0; i < off; i++) tick();
            din = ~din;
            for (int i = 0; i < 2*N + 4; i++) tick();
        end

        // Random stimulus with mixed hold times
        begin
            int hold = 0;
            for (int i = 0; i < 20000; i++) begin
                if (hold == 0) begin
                    din  = $urandom_range(1, 0) == 1;
                    hold = ($urandom_range(3, 0) == 0) ? $urandom_range(3*N, N) : $urandom_range(N, 1);
                    if ($urandom_range(15, 0) == 0) en = ~en;
                    else if (!en && $urandom_range(1, 0) == 1) en = 1'b1;
                end
                hold--;
                tick();
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule